// File: doc/BRIEF.md
# Serial Transmit Path with Handshake Gating

This block is the transmit half of an asynchronous serial port. Software-side logic pushes bytes into a 32-deep queue. A shifter takes them one at a time and sends each as a framed character on a serial line. Every bit lasts sixteen pulses of an oversampling tick that an external rate generator supplies. The frame settings are word size (7 or 8 bits), parity on or off, parity sense, and one or two stop bits. They arrive as level inputs from a control register kept elsewhere, and the receive path uses the same values.

Status outputs report queue full, queue empty, and a ready level that compares the queue fill against a trigger threshold. A completion flag is kept apart from queue-empty: it is raised only when the queue holds nothing and the shifter has gone idle as well.

A break control forces the line to the space level. An optional clear-to-send input can hold back new characters. The block synchronises that input, shows its level, and latches any change in a sticky flag that a one-cycle clear pulse resets. A loopback mode sends the serial stream to an internal receive-side output and keeps the external line at mark.

Top module: `sertx_core`

## Requirements
- R1: Each character is sent as a 0 start bit, then the data bits least significant first, then an optional parity bit, then one or two stop bits at 1. The data is 8 bits when `cfg_eight_bit`=1 and the low 7 bits when it is 0. The parity bit is the XOR of the sent data bits, inverted when `cfg_parity_odd`=1. Each bit lasts 16 `tick16` pulses, and the idle line is 1.
- R2: The queue holds 32 bytes and sends them in the order they were written.
- R3: A write while 32 bytes are held is dropped. `fifo_full` stays 1 until a byte leaves the queue.
- R4: `fifo_empty` is 1 exactly when the queue holds no byte. It is never 1 together with `fifo_full`.
- R5: `tx_ready` is 1 when the number of queued bytes is strictly less than `trig_level`.
- R6: `tx_done` is 1 only when the queue is empty and no character is being shifted. It stays 0 while the last character is still on the line.
- R7: While `cfg_break`=1, the serial output is 0.
- R8: When `cfg_flow_en`=1, `cfg_flow_ignore`=0 and the synchronised `cts_in` is 0, no new character starts. `cfg_flow_ignore`=1 removes this gating.
- R9: A character that has started always completes its full frame, even if gating or `cfg_tx_en` changes during it.
- R10: While `cfg_tx_en`=0, no new character starts and queued bytes stay queued.
- R11: `cts_level` shows `cts_in` after two-stage synchronisation. Any change of that level sets `cts_delta`, which holds until a `cts_clr` pulse. A set in the same cycle as a clear wins.
- R12: When `cfg_loopback`=1, `txd` stays 1 and `loop_rxd` carries the serial stream. When `cfg_loopback`=0, `loop_rxd` is 1.
- R13: After reset the line is 1, the queue is empty, `tx_done` is 1, `cts_delta` is 0 and `cts_level` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Oversampling tick, 16 per bit |
| wr_en | input | 1 | Push `wr_data` into the queue |
| wr_data | input | 8 | Byte to send |
| cfg_tx_en | input | 1 | Allow new characters to start |
| cfg_eight_bit | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_parity_en | input | 1 | Append a parity bit |
| cfg_parity_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_two_stop | input | 1 | 1: two stop bits |
| cfg_break | input | 1 | Force the serial output low |
| cfg_flow_en | input | 1 | Gate starts on `cts_in` |
| cfg_flow_ignore | input | 1 | Disregard `cts_in` |
| cfg_loopback | input | 1 | Route serial output internally |
| trig_level | input | 6 | Ready threshold |
| cts_in | input | 1 | Clear-to-send pin, asynchronous |
| cts_clr | input | 1 | Clear the change flag |
| txd | output | 1 | External serial line |
| loop_rxd | output | 1 | Internal loopback line to the receiver |
| fifo_full | output | 1 | Queue holds 32 bytes |
| fifo_empty | output | 1 | Queue holds no byte |
| tx_ready | output | 1 | Queue fill below threshold |
| tx_done | output | 1 | Queue empty and shifter idle |
| cts_level | output | 1 | Synchronised `cts_in` |
| cts_delta | output | 1 | Sticky change flag on `cts_in` |

## Verification
The framing is exercised with 8N1, 7E1, 8O2, 7N2 and 8E1 settings on bytes with different bit patterns. A wrong word-size cut, an inverted parity sense or a missing stop bit therefore each show up as a distinct frame mismatch. One byte whose eighth bit is set is sent in 7-bit mode, which shows that only the low bits are sent. The queue is filled to its depth with a counting pattern while sending is off, so order, the dropped 33rd write and the full flag are all observed. In separate runs, gating and enable are removed halfway through a frame: the running frame must arrive intact while the next one stays queued, which separates boundary gating from immediate stopping.

// File: rtl/sertx_pkg.sv
`timescale 1ns/1ps
package sertx_pkg;

    typedef struct packed {
        logic eight_bit;
        logic parity_en;
        logic parity_odd;
        logic two_stop;
    } frame_cfg_t;

endpackage

// File: rtl/sertx_fifo.sv
`timescale 1ns/1ps
module sertx_fifo #(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] pop_data,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic push_ok, pop_ok;

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        push_ok = push && (st_q.cnt != CW'(DEPTH));
        pop_ok  = pop && (st_q.cnt != '0);
        if (push_ok) st_d.wptr = wrap_inc(st_q.wptr);
        if (pop_ok)  st_d.rptr = wrap_inc(st_q.rptr);
        case ({push_ok, pop_ok})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[st_q.wptr] <= push_data;
    end

    assign pop_data = mem_q[st_q.rptr];
    assign count    = st_q.cnt;
    assign full     = (st_q.cnt == CW'(DEPTH));
    assign empty    = (st_q.cnt == '0);

endmodule

// File: rtl/sertx_shifter.sv
`timescale 1ns/1ps
module sertx_shifter
    import sertx_pkg::*;
#(
    parameter int DW    = 8,
    parameter int TICKS = 16,
    localparam int FW   = DW + 4,
    localparam int TCW  = $clog2(TICKS),
    localparam int BCW  = $clog2(FW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          start,
    input  logic [DW-1:0] data,
    input  frame_cfg_t    cfg,
    output logic          busy,
    output logic          line
);

    typedef struct packed {
        logic           busy;
        logic [FW-1:0]  sh;
        logic [BCW-1:0] left;
        logic [TCW-1:0] tcnt;
    } shf_st_t;

    localparam shf_st_t SHF_RST = '{busy: 1'b0, sh: '1, left: '0, tcnt: '0};

    shf_st_t st_d, st_q;

    always_comb begin
        logic [FW-1:0] frame;
        logic          par;
        int            nd;
        int            len;
        st_d  = st_q;
        nd    = cfg.eight_bit ? DW : DW - 1;
        frame = '1;
        frame[0] = 1'b0;
        par   = cfg.parity_odd;
        for (int i = 0; i < DW; i++) begin
            if (i < nd) begin
                frame[i + 1] = data[i];
                par = par ^ data[i];
            end
        end
        if (cfg.parity_en) frame[nd + 1] = par;
        len = 1 + nd + (cfg.parity_en ? 1 : 0) + (cfg.two_stop ? 2 : 1);

        if (!st_q.busy) begin
            if (start) begin
                st_d.busy = 1'b1;
                st_d.sh   = frame;
                st_d.left = BCW'(len);
                st_d.tcnt = '0;
            end
        end else if (tick) begin
            if (st_q.tcnt == TCW'(TICKS - 1)) begin
                st_d.tcnt = '0;
                st_d.sh   = {1'b1, st_q.sh[FW-1:1]};
                st_d.left = st_q.left - 1'b1;
                if (st_q.left == BCW'(1)) st_d.busy = 1'b0;
            end else begin
                st_d.tcnt = st_q.tcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SHF_RST;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;
    assign line = st_q.busy ? st_q.sh[0] : 1'b1;

endmodule

// File: rtl/sertx_handshake.sv
`timescale 1ns/1ps
module sertx_handshake (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic clr,
    output logic level,
    output logic delta
);

    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
        logic flag;
    } hs_st_t;

    localparam hs_st_t HS_RST = '{s1: 1'b1, s2: 1'b1, s3: 1'b1, flag: 1'b0};

    hs_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pin;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
        if (st_q.s2 != st_q.s3) st_d.flag = 1'b1;
        else if (clr)           st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= HS_RST;
        else        st_q <= st_d;
    end

    assign level = st_q.s2;
    assign delta = st_q.flag;

endmodule

// File: rtl/sertx_core.sv
`timescale 1ns/1ps
module sertx_core
    import sertx_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    parameter int TICKS = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick16,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          cfg_tx_en,
    input  logic          cfg_eight_bit,
    input  logic          cfg_parity_en,
    input  logic          cfg_parity_odd,
    input  logic          cfg_two_stop,
    input  logic          cfg_break,
    input  logic          cfg_flow_en,
    input  logic          cfg_flow_ignore,
    input  logic          cfg_loopback,
    input  logic [CW-1:0] trig_level,
    input  logic          cts_in,
    input  logic          cts_clr,
    output logic          txd,
    output logic          loop_rxd,
    output logic          fifo_full,
    output logic          fifo_empty,
    output logic          tx_ready,
    output logic          tx_done,
    output logic          cts_level,
    output logic          cts_delta
);

    frame_cfg_t    fcfg;
    logic [DW-1:0] head_data;
    logic [CW-1:0] fill;
    logic          sh_busy;
    logic          sh_line;
    logic          gate_ok;
    logic          start_w;
    logic          serial;

    assign fcfg = '{eight_bit: cfg_eight_bit, parity_en: cfg_parity_en,
                    parity_odd: cfg_parity_odd, two_stop: cfg_two_stop};

    sertx_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_en),
        .push_data (wr_data),
        .pop       (start_w),
        .pop_data  (head_data),
        .count     (fill),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    sertx_handshake u_hs (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (cts_in),
        .clr   (cts_clr),
        .level (cts_level),
        .delta (cts_delta)
    );

    assign gate_ok = !cfg_flow_en || cfg_flow_ignore || cts_level;
    assign start_w = !sh_busy && !fifo_empty && cfg_tx_en && gate_ok;

    sertx_shifter #(.DW(DW), .TICKS(TICKS)) u_shf (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick16),
        .start (start_w),
        .data  (head_data),
        .cfg   (fcfg),
        .busy  (sh_busy),
        .line  (sh_line)
    );

    assign serial   = cfg_break ? 1'b0 : sh_line;
    assign txd      = cfg_loopback ? 1'b1 : serial;
    assign loop_rxd = cfg_loopback ? serial : 1'b1;
    assign tx_ready = (fill < trig_level);
    assign tx_done  = fifo_empty && !sh_busy;

endmodule

// File: rtl/sertx_core_chk.sv
`timescale 1ns/1ps
module sertx_core_chk (
    input logic clk,
    input logic rst_n,
    input logic tick16,
    input logic cfg_tx_en,
    input logic cfg_flow_en,
    input logic cfg_flow_ignore,
    input logic fifo_full,
    input logic fifo_empty,
    input logic tx_done,
    input logic cts_level,
    input logic cts_delta,
    input logic busy,
    input logic start
);

    // R1: a character ends only on an oversampling tick
    p_end_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(tick16));

    // R3: a full queue stays full unless a byte leaves
    p_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && !start) |=> fifo_full);

    // R4: full and empty never together
    p_flags_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));

    // R6: completion rises only as the shifter goes idle
    p_done_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> $fell(busy));

    // R8, R10: a character starts only when enabled and not gated
    p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(cfg_tx_en) &&
                         ($past(cts_level) || !$past(cfg_flow_en) || $past(cfg_flow_ignore))));

    // R11: a level change on the handshake input sets the sticky flag
    p_delta_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cts_level != $past(cts_level)) |=> cts_delta);

endmodule

bind sertx_core sertx_core_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .tick16          (tick16),
    .cfg_tx_en       (cfg_tx_en),
    .cfg_flow_en     (cfg_flow_en),
    .cfg_flow_ignore (cfg_flow_ignore),
    .fifo_full       (fifo_full),
    .fifo_empty      (fifo_empty),
    .tx_done         (tx_done),
    .cts_level       (cts_level),
    .cts_delta       (cts_delta),
    .busy            (sh_busy),
    .start           (start_w)
);

// File: tb/sertx_core_bench.sv
`timescale 1ns/1ps
module sertx_core_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       cfg_tx_en = 1'b0, cfg_eight_bit = 1'b1, cfg_parity_en = 1'b0;
    logic       cfg_parity_odd = 1'b0, cfg_two_stop = 1'b0, cfg_break = 1'b0;
    logic       cfg_flow_en = 1'b0, cfg_flow_ignore = 1'b0, cfg_loopback = 1'b0;
    logic [5:0] trig_level = 6'd2;
    logic       cts_in = 1'b1, cts_clr = 1'b0;
    logic       txd, loop_rxd, fifo_full, fifo_empty, tx_ready, tx_done, cts_level, cts_delta;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  mon_on = 1'b1;
    bit  mon_loop = 1'b0;
    bit  watch_txd = 1'b0;
    bit  txd_low_seen = 1'b0;
    logic [11:0] exp_q[$];
    int          len_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) tick16 <= ~tick16;

    sertx_core u_sertx_core (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .wr_en(wr_en), .wr_data(wr_data),
        .cfg_tx_en(cfg_tx_en), .cfg_eight_bit(cfg_eight_bit), .cfg_parity_en(cfg_parity_en),
        .cfg_parity_odd(cfg_parity_odd), .cfg_two_stop(cfg_two_stop), .cfg_break(cfg_break),
        .cfg_flow_en(cfg_flow_en), .cfg_flow_ignore(cfg_flow_ignore), .cfg_loopback(cfg_loopback),
        .trig_level(trig_level), .cts_in(cts_in), .cts_clr(cts_clr),
        .txd(txd), .loop_rxd(loop_rxd), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
        .tx_ready(tx_ready), .tx_done(tx_done), .cts_level(cts_level), .cts_delta(cts_delta)
    );

    task automatic chk_eq(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    function automatic logic mline();
        return mon_loop ? loop_rxd : txd;
    endfunction

    // R1: expected frame from the requirement, bit 0 sent first
    function automatic logic [11:0] mk_frame(input logic [7:0] b, output int len);
        logic [11:0] fr;
        int nd;
        logic par;
        fr = '1;
        fr[0] = 1'b0;
        nd = cfg_eight_bit ? 8 : 7;
        par = 1'b0;
        for (int i = 0; i < nd; i++) begin
            fr[1 + i] = b[i];
            par ^= b[i];
        end
        if (cfg_parity_odd) par = ~par;
        len = 1 + nd;
        if (cfg_parity_en) begin
            fr[len] = par;
            len++;
        end
        len += cfg_two_stop ? 2 : 1;
        return fr;
    endfunction

    task automatic raw_write(input logic [7:0] b);
        wr_en = 1'b1;
        wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic push_byte(input logic [7:0] b);
        int len;
        logic [11:0] fr;
        fr = mk_frame(b, len);
        exp_q.push_back(fr);
        len_q.push_back(len);
        raw_write(b);
    endtask

    task automatic wait_ticks(input int n);
        int c = 0;
        while (c < n) begin
            @(negedge clk);
            if (tick16) c++;
        end
    endtask

    task automatic drain();
        do @(negedge clk); while (!(exp_q.size() == 0 && tx_done));
    endtask

    task automatic wait_line_low();
        do @(negedge clk); while (mline() != 1'b0);
    endtask

    always @(negedge clk) if (watch_txd && txd !== 1'b1) txd_low_seen = 1'b1;

    // monitor: rebuilds each frame from the line and compares with the queue
    initial begin : monitor
        forever begin
            @(negedge clk);
            if (mon_on && rst_n && mline() == 1'b0) begin
                logic [11:0] got;
                int len;
                bit expd;
                got = '1;
                expd = (exp_q.size() != 0);
                len = expd ? len_q[0] : 10;
                wait_ticks(8);
                got[0] = mline();
                for (int k = 1; k < len; k++) begin
                    wait_ticks(16);
                    got[k] = mline();
                end
                if (expd) begin
                    chk_eq("R1/R2 frame", int'(got), int'(exp_q[0]));
                    void'(exp_q.pop_front());
                    void'(len_q.pop_front());
                end else begin
                    chk_eq("R2 unexpected frame", int'(got), 0);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin : main
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        chk_eq("R13 txd", txd, 1);
        chk_eq("R13 loop_rxd", loop_rxd, 1);
        chk_eq("R13 empty", fifo_empty, 1);
        chk_eq("R13 full", fifo_full, 0);
        chk_eq("R13 done", tx_done, 1);
        chk_eq("R13 delta", cts_delta, 0);
        chk_eq("R13 level", cts_level, 1);
        chk_eq("R5 ready at zero fill", tx_ready, 1);

        // R5 threshold, R10 disabled sending holds bytes
        push_byte(8'h11);
        chk_eq("R5 ready fill1", tx_ready, 1);
        chk_eq("R4 empty fill1", fifo_empty, 0);
        push_byte(8'hA3);
        chk_eq("R5 ready fill2", tx_ready, 0);
        repeat (100) @(negedge clk);
        chk_eq("R10 held while disabled", fifo_empty, 0);
        cfg_tx_en = 1'b1;
        drain();

        // R1 formats: 7E1
        cfg_eight_bit = 1'b0; cfg_parity_en = 1'b1; cfg_parity_odd = 1'b0;
        push_byte(8'h41); push_byte(8'hFF);
        drain();
        // 8O2
        cfg_eight_bit = 1'b1; cfg_parity_odd = 1'b1; cfg_two_stop = 1'b1;
        push_byte(8'h00); push_byte(8'hC5);
        drain();
        // 7N2
        cfg_eight_bit = 1'b0; cfg_parity_en = 1'b0;
        push_byte(8'h2C);
        drain();
        // 8E1
        cfg_eight_bit = 1'b1; cfg_parity_en = 1'b1; cfg_parity_odd = 1'b0; cfg_two_stop = 1'b0;
        push_byte(8'h96);
        drain();
        cfg_parity_en = 1'b0;

        // R6 done stays low while the last character shifts
        push_byte(8'h5A);
        do @(negedge clk); while (!fifo_empty);
        chk_eq("R6 done low while shifting", tx_done, 0);
        drain();
        chk_eq("R6 done after idle", tx_done, 1);

        // R2 / R3 fill to depth, overflow write dropped
        cfg_tx_en = 1'b0;
        for (int i = 0; i < 32; i++) push_byte(8'(i * 7 + 3));
        chk_eq("R3 full at 32", fifo_full, 1);
        chk_eq("R4 not empty at 32", fifo_empty, 0);
        raw_write(8'hEE);
        chk_eq("R3 full after dropped write", fifo_full, 1);
        cfg_tx_en = 1'b1;
        repeat (3) @(negedge clk);
        chk_eq("R3 full clears after a pop", fifo_full, 0);
        drain();

        // R9 / R10 disable mid-frame
        push_byte(8'h3C); push_byte(8'hC3);
        wait_line_low();
        cfg_tx_en = 1'b0;
        while (exp_q.size() != 1) @(negedge clk);
        repeat (700) @(negedge clk);
        chk_eq("R10 next held after disable", fifo_empty, 0);
        cfg_tx_en = 1'b1;
        drain();

        // R11 delta flag
        cts_clr = 1'b1; @(negedge clk); cts_clr = 1'b0;
        cfg_flow_en = 1'b1;
        cts_in = 1'b0;
        repeat (4) @(negedge clk);
        chk_eq("R11 level follows pin", cts_level, 0);
        chk_eq("R11 delta set", cts_delta, 1);
        repeat (3) @(negedge clk);
        chk_eq("R11 delta sticky", cts_delta, 1);
        cts_clr = 1'b1; @(negedge clk); cts_clr = 1'b0;
        chk_eq("R11 delta cleared", cts_delta, 0);

        // R8 gating and ignore
        push_byte(8'h69);
        repeat (300) @(negedge clk);
        chk_eq("R8 gated start", fifo_empty, 0);
        chk_eq("R8 line idle while gated", txd, 1);
        cfg_flow_ignore = 1'b1;
        drain();
        cfg_flow_ignore = 1'b0;

        // R9 gating drops mid-frame
        cts_in = 1'b1;
        repeat (4) @(negedge clk);
        chk_eq("R11 delta on rise", cts_delta, 1);
        push_byte(8'hB2); push_byte(8'h4D);
        wait_line_low();
        cts_in = 1'b0;
        while (exp_q.size() != 1) @(negedge clk);
        repeat (700) @(negedge clk);
        chk_eq("R9 R8 second char held", fifo_empty, 0);
        cts_in = 1'b1;
        drain();
        cfg_flow_en = 1'b0;

        // R7 break
        mon_on = 1'b0;
        cfg_break = 1'b1;
        repeat (3) @(negedge clk);
        chk_eq("R7 break drives low", txd, 0);
        cfg_break = 1'b0;
        repeat (2) @(negedge clk);
        chk_eq("R7 release idles high", txd, 1);
        mon_on = 1'b1;

        // R12 loopback
        cfg_loopback = 1'b1; mon_loop = 1'b1; watch_txd = 1'b1;
        push_byte(8'hE1); push_byte(8'h18);
        drain();
        chk_eq("R12 txd held high in loopback", txd_low_seen, 0);
        cfg_loopback = 1'b0; mon_loop = 1'b0; watch_txd = 1'b0;
        @(negedge clk);
        chk_eq("R12 loop_rxd idle outside loopback", loop_rxd, 1);

        chk_eq("R2 all frames seen", exp_q.size(), 0);
        summary();
    end

endmodule